// File: doc/BRIEF.md
# Accelerator Error Interrupt Controller

This block gathers thirteen hardware error pulses from a data compression engine and holds each one in a sticky source register until software clears it. Software reaches the block through a small word-addressed register port. The registers cover the latched sources, an interrupt mask, an injection register that forces errors in, the masked status, three class-enable registers, a control register, a shutdown-select register and an ECC information register.

Each pending, unmasked error is sorted into up to three classes: correctable, non-fatal and fatal. One level interrupt output is driven per class. When shutdown is enabled, a selected non-fatal error also raises a request to halt the engine's bus master. When a multi-bit SRAM ECC error is reported, the block records the error count and the failing address that come with the pulse.

The error sources are assigned as follows:

| Bit | Source |
|---|---|
| 0 | single-bit ECC |
| 1 | multi-bit ECC |
| 2 | bus read response error |
| 3 | bus write response error |
| 4 | source address parse error |
| 5 | destination address parse error |
| 11 | bus poison |
| 12 | address translation error |

Bits 6 to 10 are other engine faults.

Top module: `err_irq_ctrl`

## Requirements
- R1: After reset, the registers hold these values:

  | Register | Reset value |
  |---|---|
  | mask | 0x1FFF |
  | correctable enable | 0x0001 |
  | non-fatal enable | 0x1FFE |
  | fatal enable | 0 |
  | source | 0 |
  | control | 0 |
  | shutdown select | 0 |
  | ECC info | 0 |

  All four outputs are low after reset.
- R2: A 1 on `hw_err[i]` sets source bit i at the next clock edge. The bit then stays set until software clears it.
- R3: A write to the source register (address 0) clears exactly the bits written as 1 and leaves all other bits unchanged.
- R4: If a hardware pulse and a clear write hit the same bit in the same cycle, the bit stays set.
- R5: A write to the set register (address 2) sets the source bits written as 1. Reads of address 2 return 0.
- R6: The status register (address 3) reads as source AND NOT mask, where a mask bit of 1 blocks that bit. The mask (address 1) has no effect on the source register.
- R7: Each class output is the OR of status AND that class's enable. The enables are at these addresses:

  | Class | Address |
  |---|---|
  | correctable | 4 |
  | non-fatal | 5 |
  | fatal | 6 |

  Each output follows register changes one clock edge after the write or pulse.
- R8: `mst_shutdown` is high only while control bit 14 is set and status AND non-fatal enable AND shutdown select (address 8) is non-zero.
- R9: A pulse on `hw_err[1]` loads the ECC info register (address 9) as follows: `ecc_cnt` goes to bits [23:16], `ecc_addr` goes to bits [31:24], and bits [15:0] read 0. At all other times the info register holds its value.
- R10: Register bits that are not implemented read 0. For the error registers these are bits 31:13. For the control register (address 7), every bit except bit 14 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_err | input | NUM_ERR | Error pulses from the engine |
| ecc_cnt | input | 8 | Multi-bit ECC error count, valid with hw_err[1] |
| ecc_addr | input | 8 | Multi-bit ECC failing address, valid with hw_err[1] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_ce | output | 1 | Correctable error interrupt |
| irq_nfe | output | 1 | Non-fatal error interrupt |
| irq_fe | output | 1 | Fatal error interrupt |
| mst_shutdown | output | 1 | Bus master shutdown request |

## Verification
A wrong source bit appears one clock edge after the faulty update, both in reads of the source or status register and on the class interrupt outputs, because all four outputs decode the registers directly. A bad mask or enable value shows up in the same cycle as an interrupt that is wrongly high or wrongly low. A wrong ECC capture stays visible in the info register until the next multi-bit pulse. The bench therefore samples every output and readback on the cycle right after each write or pulse.

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl #(
  parameter int NUM_ERR  = 13,
  parameter int AW       = 4,
  parameter int ECC_BIT  = 1,
  parameter int SHUT_BIT = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] hw_err,
  input  logic [7:0]         ecc_cnt,
  input  logic [7:0]         ecc_addr,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_ce,
  output logic               irq_nfe,
  output logic               irq_fe,
  output logic               mst_shutdown
);
  localparam logic [AW-1:0] A_SRC  = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_SET  = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_CE   = AW'(4);
  localparam logic [AW-1:0] A_NFE  = AW'(5);
  localparam logic [AW-1:0] A_FE   = AW'(6);
  localparam logic [AW-1:0] A_CTRL = AW'(7);
  localparam logic [AW-1:0] A_SEL  = AW'(8);
  localparam logic [AW-1:0] A_INFO = AW'(9);
  localparam logic [NUM_ERR-1:0] ALL_ONES = '1;
  localparam logic [NUM_ERR-1:0] CE_RST   = NUM_ERR'(1);
  localparam logic [NUM_ERR-1:0] NFE_RST  = ALL_ONES & ~CE_RST;

  logic [NUM_ERR-1:0] src_q, mask_q, ce_en_q, nfe_en_q, fe_en_q, sel_q;
  logic               shut_en_q;
  logic [15:0]        info_q;
  logic [NUM_ERR-1:0] wbits, clr, inj, status;

  assign wbits  = reg_wdata[NUM_ERR-1:0];
  assign clr    = (reg_wr && reg_addr == A_SRC) ? wbits : '0;
  assign inj    = (reg_wr && reg_addr == A_SET) ? wbits : '0;
  assign status = src_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      mask_q    <= ALL_ONES;
      ce_en_q   <= CE_RST;
      nfe_en_q  <= NFE_RST;
      fe_en_q   <= '0;
      sel_q     <= '0;
      shut_en_q <= 1'b0;
      info_q    <= '0;
    end else begin
      src_q <= (src_q & ~clr) | hw_err | inj;
      if (hw_err[ECC_BIT]) info_q <= {ecc_addr, ecc_cnt};
      if (reg_wr) begin
        case (reg_addr)
          A_MASK:  mask_q    <= wbits;
          A_CE:    ce_en_q   <= wbits;
          A_NFE:   nfe_en_q  <= wbits;
          A_FE:    fe_en_q   <= wbits;
          A_CTRL:  shut_en_q <= reg_wdata[SHUT_BIT];
          A_SEL:   sel_q     <= wbits;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_SRC:   reg_rdata = 32'(src_q);
      A_MASK:  reg_rdata = 32'(mask_q);
      A_STAT:  reg_rdata = 32'(status);
      A_CE:    reg_rdata = 32'(ce_en_q);
      A_NFE:   reg_rdata = 32'(nfe_en_q);
      A_FE:    reg_rdata = 32'(fe_en_q);
      A_CTRL:  reg_rdata = 32'(shut_en_q) << SHUT_BIT;
      A_SEL:   reg_rdata = 32'(sel_q);
      A_INFO:  reg_rdata = {info_q, 16'h0000};
      default: reg_rdata = 32'h0;
    endcase
  end

  assign irq_ce       = |(status & ce_en_q);
  assign irq_nfe      = |(status & nfe_en_q);
  assign irq_fe       = |(status & fe_en_q);
  assign mst_shutdown = shut_en_q && |(status & nfe_en_q & sel_q);
endmodule

module err_irq_ctrl_chk #(
  parameter int NUM_ERR = 13,
  parameter int AW      = 4,
  parameter int ECC_BIT = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_ERR-1:0] hw_err,
  input logic               reg_wr,
  input logic [AW-1:0]      reg_addr,
  input logic [NUM_ERR-1:0] src_q,
  input logic [NUM_ERR-1:0] mask_q,
  input logic               shut_en_q,
  input logic [15:0]        info_q,
  input logic               irq_ce,
  input logic               irq_nfe,
  input logic               irq_fe,
  input logic               mst_shutdown
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '1 && src_q == '0 && !shut_en_q));

  a_r4_error_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_err != '0) |=> ((src_q & $past(hw_err)) == $past(hw_err)));

  a_r3_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == AW'(0)) |=> ((src_q & $past(src_q)) == $past(src_q)));

  a_r7_full_mask_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !(irq_ce || irq_nfe || irq_fe));

  a_r8_shutdown_needs_nfe: assert property (@(posedge clk) disable iff (!rst_n)
    mst_shutdown |-> (shut_en_q && irq_nfe));

  a_r9_info_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_err[ECC_BIT] |=> $stable(info_q));
endmodule

bind err_irq_ctrl err_irq_ctrl_chk #(.NUM_ERR(NUM_ERR), .AW(AW), .ECC_BIT(ECC_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_err(hw_err), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .src_q(src_q), .mask_q(mask_q), .shut_en_q(shut_en_q), .info_q(info_q),
  .irq_ce(irq_ce), .irq_nfe(irq_nfe), .irq_fe(irq_fe), .mst_shutdown(mst_shutdown)
);

// File: tb/err_irq_ctrl_test.sv
module err_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] hw_err = '0;
  logic [7:0]  ecc_cnt = '0, ecc_addr = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_ce, irq_nfe, irq_fe, mst_shutdown;

  err_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hw_err(hw_err), .ecc_cnt(ecc_cnt), .ecc_addr(ecc_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ce(irq_ce), .irq_nfe(irq_nfe), .irq_fe(irq_fe), .mst_shutdown(mst_shutdown)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    bit          outs;
    string       req;
  } item_t;

  item_t       q[$];
  item_t       cur;
  logic [31:0] act;
  logic        mon_req = 1'b0;
  bit          done = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always @(negedge clk) begin
    if (mon_req && q.size() > 0) begin
      cur = q.pop_front();
      act = cur.outs ? {28'h0, irq_fe, irq_nfe, irq_ce, mst_shutdown} : reg_rdata;
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", cur.req, act, cur.exp);
      end
    end
  end

  task automatic push_chk(input logic [3:0] a, input logic [31:0] e, input bit o, input string r);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.exp = e; it.outs = o; it.req = r;
    q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string r);
    push_chk(a, e, 1'b0, r);
  endtask

  // outputs packed as {irq_fe, irq_nfe, irq_ce, mst_shutdown}
  task automatic outs(input logic [3:0] e, input string r);
    push_chk(reg_addr, {28'h0, e}, 1'b1, r);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [12:0] b, input logic [7:0] c, input logic [7:0] ad);
    @(posedge clk); #1;
    hw_err = b; ecc_cnt = c; ecc_addr = ad;
    @(posedge clk); #1;
    hw_err = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(4'd1, 32'h1FFF, "R1 mask");
    rd(4'd4, 32'h1, "R1 ce_en");
    rd(4'd5, 32'h1FFE, "R1 nfe_en");
    rd(4'd6, 32'h0, "R1 fe_en");
    rd(4'd0, 32'h0, "R1 source");
    outs(4'h0, "R1 outputs");
    // R2 latch, R6 masked status
    pulse(13'h008, 8'h0, 8'h0);
    rd(4'd0, 32'h8, "R2 latched");
    rd(4'd3, 32'h0, "R6 status masked");
    outs(4'h0, "R7 masked out");
    wr(4'd1, 32'h0);
    rd(4'd3, 32'h8, "R6 status unmasked");
    outs(4'h4, "R7 nfe raised");
    // R3 W1C
    wr(4'd0, 32'h8);
    rd(4'd0, 32'h0, "R3 cleared");
    outs(4'h0, "R7 nfe dropped");
    pulse(13'h021, 8'h0, 8'h0);
    outs(4'h6, "R7 ce and nfe");
    wr(4'd0, 32'h1);
    rd(4'd0, 32'h20, "R3 selective clear");
    outs(4'h4, "R7 only nfe");
    // R4 collision
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h20; hw_err = 13'h020;
    @(posedge clk); #1;
    reg_wr = 1'b0; hw_err = '0;
    rd(4'd0, 32'h20, "R4 error wins");
    wr(4'd0, 32'h20);
    rd(4'd0, 32'h0, "R3 clear after collision");
    // R5 injection
    wr(4'd2, 32'h1000);
    rd(4'd0, 32'h1000, "R5 injected");
    rd(4'd2, 32'h0, "R5 set reads zero");
    // R8 shutdown
    wr(4'd8, 32'h1000);
    outs(4'h4, "R8 shutdown disabled");
    wr(4'd7, 32'hFFFF_FFFF);
    outs(4'h5, "R8 shutdown asserted");
    rd(4'd7, 32'h4000, "R10 control bits");
    wr(4'd7, 32'h0);
    outs(4'h4, "R8 shutdown released");
    wr(4'd7, 32'h4000);
    wr(4'd8, 32'h0);
    outs(4'h4, "R8 not selected");
    // R7 fatal, R6 mask does not touch source
    wr(4'd6, 32'h1000);
    outs(4'hC, "R7 fatal raised");
    wr(4'd1, 32'h1000);
    rd(4'd3, 32'h0, "R6 status masked bit12");
    outs(4'h0, "R7 mask silences");
    rd(4'd0, 32'h1000, "R6 source untouched");
    // R9 ECC info
    pulse(13'h002, 8'h5A, 8'hC3);
    rd(4'd9, 32'hC35A_0000, "R9 info captured");
    outs(4'h4, "R7 ecc nfe");
    pulse(13'h001, 8'h11, 8'h22);
    rd(4'd9, 32'hC35A_0000, "R9 info held");
    // R10 width
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h1FFF, "R10 mask width");
    outs(4'h0, "R7 all masked");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule